// File: doc/BRIEF.md
# Configuration Space Unlock Sequencer

This block protects a Super I/O style configuration register space behind a four-byte key. The host reaches the block through a byte-wide write/read interface with a single port-select bit: one value selects the index port, the other selects the data port. While the space is locked, every byte written to the index port is fed to a key matcher. Nothing else has any effect. Only when the whole key has arrived in order does the space open.

Once open, the block behaves as an index/data pair. A write to the index port picks a configuration register, and data-port accesses then read or write that register. The space offers a two-byte chip identity, a logical device selector, and a small register file for each logical device. Writing the close code to the control register locks the space again. A strap input chooses which of two base addresses the block answers at. That choice changes the last byte of the key.

Top module: `cfg_unlock_seq`

## Requirements
- R1: The space opens only after the bytes 0x87, 0x01, 0x55 and a final byte are written in that order to the index port (port_sel=0). `cfg_open` goes high after the clock edge that samples the fourth byte and stays low after the first three.
- R2: The final key byte is 0x55 when `strap_alt`=0 (base port 0x2E) and 0xAA when `strap_alt`=1 (base port 0x4E). The other strap's final byte does not open the space.
- R3: A wrong byte at any key position returns the matcher to idle. If that wrong byte is 0x87, it is taken as the first key byte, so that 0x01, 0x55 and the final byte then open the space.
- R4: While open, a data-port write (port_sel=1) of 0x02 with index 0x02 closes the space after that edge and clears the index to 0x00. Other values written to 0x02, or 0x02 written to other registers, leave the space open.
- R5: While open, data reads at index 0x20 and 0x21 return the high and low bytes of the `CHIP_ID` parameter (default 0x8716).
- R6: While locked, reads of either port return 0xFF. Data-port writes are ignored, and index-port writes change neither the index, the logical device select nor any device register.
- R7: Index 0x07 holds the logical device number. It keeps the low log2(`NUM_LDN`) bits of the written byte and reads back zero-extended. Indices 0x30 to 0x30+`DEV_REGS`-1 reach the selected device's own registers. All other indices read 0x00 and ignore writes, and this includes the identity registers.
- R8: Reset (synchronous, active low) locks the space, clears the key matcher, selects logical device 0, and clears the index and every device register to 0x00.
- R9: `rd_data` is updated at the clock edge that samples `rd_en` and holds its value otherwise. While open, an index-port read returns the current index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_alt | input | 1 | Base select: 0 = port 0x2E, 1 = port 0x4E |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| cfg_open | output | 1 | High while the configuration space is unlocked |

## Verification
Every result appears one clock edge after the stimulus that causes it:
- `cfg_open` rises on the edge that samples the fourth key byte.
- `cfg_open` falls on the edge that samples the close write.
- `rd_data` changes on the edge that samples `rd_en`.

The bench drives each access on a falling edge and removes it on the next falling edge. It reads outputs at that second falling edge, which lies half a period after the single register stage that produced them. Wrong-byte placement is swept over every key position and both straps. All device registers of every logical device are written and read back.

// File: rtl/cfg_unlock_pkg.sv
// Package: constants and types shared by the unlock sequencer.
// Assumes byte-wide host accesses; key and register codes are fixed here.
package cfg_unlock_pkg;

    localparam logic [7:0] KEY_BYTE0    = 8'h87;
    localparam logic [7:0] KEY_BYTE1    = 8'h01;
    localparam logic [7:0] KEY_BYTE2    = 8'h55;
    localparam logic [7:0] KEY_FIN_PRI  = 8'h55;  // base port 0x2E
    localparam logic [7:0] KEY_FIN_ALT  = 8'hAA;  // base port 0x4E

    localparam logic [7:0] IDX_CTRL     = 8'h02;
    localparam logic [7:0] CTRL_CLOSE   = 8'h02;
    localparam logic [7:0] IDX_LDN      = 8'h07;
    localparam logic [7:0] IDX_ID_HI    = 8'h20;
    localparam logic [7:0] IDX_ID_LO    = 8'h21;
    localparam logic [7:0] IDX_DEV_BASE = 8'h30;

    localparam logic [7:0] LOCKED_READ  = 8'hFF;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_GOT1,
        KS_GOT2,
        KS_GOT3,
        KS_OPEN
    } key_state_t;

endpackage

// File: rtl/cfg_key_match.sv
// Key matcher: tracks index-port bytes while locked and opens the
// configuration space after the full four-byte key. A mismatch returns
// to idle unless the mismatching byte is the first key byte.
// Assumes key_wr is only asserted for index-port writes.
module cfg_key_match
    import cfg_unlock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_alt,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       close_req,
    output logic       open
);

    key_state_t state_q;
    key_state_t state_d;
    logic [7:0] expect_byte;
    logic [7:0] final_byte;

    // Select the last key byte from the base-port strap.
    assign final_byte = strap_alt ? KEY_FIN_ALT : KEY_FIN_PRI;

    // Byte the matcher waits for in each state.
    always_comb begin
        case (state_q)
            KS_GOT1: expect_byte = KEY_BYTE1;
            KS_GOT2: expect_byte = KEY_BYTE2;
            KS_GOT3: expect_byte = final_byte;
            default: expect_byte = KEY_BYTE0;
        endcase
    end

    // Next-state rule: advance on a match, restart on a stray first byte.
    always_comb begin
        state_d = state_q;
        if (state_q == KS_OPEN) begin
            if (close_req) state_d = KS_IDLE;
        end else if (key_wr) begin
            if (key_byte == expect_byte) begin
                case (state_q)
                    KS_IDLE: state_d = KS_GOT1;
                    KS_GOT1: state_d = KS_GOT2;
                    KS_GOT2: state_d = KS_GOT3;
                    default: state_d = KS_OPEN;
                endcase
            end else if (key_byte == KEY_BYTE0) begin
                state_d = KS_GOT1;
            end else begin
                state_d = KS_IDLE;
            end
        end
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    assign open = (state_q == KS_OPEN);

endmodule

// File: rtl/cfg_ldn_bank.sv
// Per-device register file: one small byte array per logical device,
// written and read through the currently selected device number.
// Assumes NUM_LDN is a power of two and at least 2.
module cfg_ldn_bank #(
    parameter int NUM_LDN  = 4,
    parameter int DEV_REGS = 16,
    localparam int LDN_W   = $clog2(NUM_LDN),
    localparam int RA_W    = (DEV_REGS > 1) ? $clog2(DEV_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LDN_W-1:0] ldn,
    input  logic [RA_W-1:0]  addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata
);

    logic [7:0] dev_rd [NUM_LDN];

    for (genvar g = 0; g < NUM_LDN; g++) begin : g_dev
        logic [7:0] mem_q [DEV_REGS];

        // Store one byte when this device is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < DEV_REGS; i++) mem_q[i] <= 8'h00;
            end else if (wr_en && (ldn == LDN_W'(g))) begin
                mem_q[addr] <= wdata;
            end
        end

        assign dev_rd[g] = mem_q[addr];
    end

    assign rdata = dev_rd[ldn];

endmodule

// File: rtl/cfg_unlock_seq.sv
// Top: index/data configuration port guarded by a key sequence.
// Holds the index and logical device select, decodes data accesses and
// registers the read byte. Assumes at most one of the two ports is
// addressed per cycle (port_sel) and that strap_alt is static.
module cfg_unlock_seq
    import cfg_unlock_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'h8716,
    parameter int          NUM_LDN  = 4,
    parameter int          DEV_REGS = 16,
    localparam int         LDN_W    = $clog2(NUM_LDN),
    localparam int         RA_W     = (DEV_REGS > 1) ? $clog2(DEV_REGS) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_alt,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       port_sel,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       cfg_open
);

    logic [7:0]       idx_q;
    logic [LDN_W-1:0] ldn_q;
    logic [7:0]       rd_q;
    logic [7:0]       rd_val;
    logic [7:0]       dev_off;
    logic [7:0]       bank_rdata;
    logic             idx_wr;
    logic             dat_wr;
    logic             close_req;
    logic             dev_hit;
    logic             open;

    assign idx_wr    = wr_en && !port_sel;
    assign dat_wr    = wr_en &&  port_sel;
    assign close_req = open && dat_wr && (idx_q == IDX_CTRL) && (wr_data == CTRL_CLOSE);
    assign dev_off   = idx_q - IDX_DEV_BASE;
    assign dev_hit   = (idx_q >= IDX_DEV_BASE) && (dev_off < 8'(DEV_REGS));

    cfg_key_match i_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .key_wr    (idx_wr && !open),
        .key_byte  (wr_data),
        .close_req (close_req),
        .open      (open)
    );

    cfg_ldn_bank #(
        .NUM_LDN  (NUM_LDN),
        .DEV_REGS (DEV_REGS)
    ) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (open && dat_wr && dev_hit),
        .ldn   (ldn_q),
        .addr  (dev_off[RA_W-1:0]),
        .wdata (wr_data),
        .rdata (bank_rdata)
    );

    // Index register: loaded by index writes while open, cleared on close.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idx_q <= 8'h00;
        else if (close_req)         idx_q <= 8'h00;
        else if (open && idx_wr)    idx_q <= wr_data;
    end

    // Logical device select: low bits of a data write at the select index.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    ldn_q <= '0;
        else if (open && dat_wr && idx_q == IDX_LDN)   ldn_q <= wr_data[LDN_W-1:0];
    end

    // Read decode: locked reads float high, open reads follow the index.
    always_comb begin
        rd_val = LOCKED_READ;
        if (open) begin
            if (!port_sel) begin
                rd_val = idx_q;
            end else if (dev_hit) begin
                rd_val = bank_rdata;
            end else begin
                case (idx_q)
                    IDX_ID_HI: rd_val = CHIP_ID[15:8];
                    IDX_ID_LO: rd_val = CHIP_ID[7:0];
                    IDX_LDN:   rd_val = {{(8-LDN_W){1'b0}}, ldn_q};
                    default:   rd_val = 8'h00;
                endcase
            end
        end
    end

    // Read register: captures the decoded byte on a read strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= LOCKED_READ;
        else if (rd_en)  rd_q <= rd_val;
    end

    assign rd_data  = rd_q;
    assign cfg_open = open;

endmodule

// File: rtl/cfg_unlock_checks.sv
// Checker: temporal properties of the unlock sequencer, bound to the top.
// Assumes it sees the top's ports plus its index and device select.
module cfg_unlock_checks
    import cfg_unlock_pkg::*;
#(
    parameter logic [15:0] CHIP_ID = 16'h8716,
    parameter int          LDN_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strap_alt,
    input logic             wr_en,
    input logic             rd_en,
    input logic             port_sel,
    input logic [7:0]       wr_data,
    input logic [7:0]       rd_data,
    input logic             cfg_open,
    input logic [7:0]       idx_q,
    input logic [LDN_W-1:0] ldn_q
);

    // R1, R2: opening is always caused by a final key byte on the index port.
    p_open_on_final_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(wr_en && !port_sel &&
            wr_data == (strap_alt ? KEY_FIN_ALT : KEY_FIN_PRI)));

    // R4: the close code at the control index locks the space.
    p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && wr_en && port_sel && idx_q == IDX_CTRL && wr_data == CTRL_CLOSE)
        |=> !cfg_open);

    // R5: identity reads.
    p_id_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && rd_en && port_sel && idx_q == IDX_ID_HI) |=> rd_data == CHIP_ID[15:8]);

    p_id_lo_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && rd_en && port_sel && idx_q == IDX_ID_LO) |=> rd_data == CHIP_ID[7:0]);

    // R6: locked reads return all ones.
    p_locked_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && rd_en) |=> rd_data == LOCKED_READ);

    // R6: nothing written while locked moves the device select.
    p_locked_ldn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(ldn_q));

    // R6: the index does not move while locked.
    p_locked_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && !$past(cfg_open)) |-> $stable(idx_q));

    // R9: read data holds without a read strobe.
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

bind cfg_unlock_seq cfg_unlock_checks #(
    .CHIP_ID (CHIP_ID),
    .LDN_W   (LDN_W)
) i_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_alt (strap_alt),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .port_sel  (port_sel),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cfg_open  (cfg_open),
    .idx_q     (idx_q),
    .ldn_q     (ldn_q)
);

// File: tb/test_cfg_unlock_seq.sv
module test_cfg_unlock_seq;

    localparam int NUM_LDN  = 4;
    localparam int DEV_REGS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_alt = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic       port_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cfg_open;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_unlock_seq #(
        .CHIP_ID  (16'h8716),
        .NUM_LDN  (NUM_LDN),
        .DEV_REGS (DEV_REGS)
    ) i_cfg_unlock_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .port_sel  (port_sel),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .cfg_open  (cfg_open)
    );

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic alt);
        @(negedge clk);
        rst_n = 1'b0;
        strap_alt = alt;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic p, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; port_sel = p; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic p, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; port_sel = p;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] v);
        wr(1'b0, idx);
        rd(1'b1, v);
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
        wr(1'b0, idx);
        wr(1'b1, v);
    endtask

    function automatic logic [7:0] fin_of(input logic alt);
        return alt ? 8'hAA : 8'h55;
    endfunction

    task automatic send_key(input logic [7:0] fin);
        wr(1'b0, 8'h87);
        wr(1'b0, 8'h01);
        wr(1'b0, 8'h55);
        wr(1'b0, fin);
    endtask

    task automatic close_space();
        reg_wr(8'h02, 8'h02);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;

        do_reset(1'b0);
        // R8: reset state
        check8("R8 open after reset", {7'd0, cfg_open}, 8'h00);
        check8("R8 reset rd_data", rd_data, 8'hFF);
        rd(1'b1, v);
        check8("R6 locked data read", v, 8'hFF);
        rd(1'b0, v);
        check8("R6 locked index read", v, 8'hFF);

        // R1, R2: open timing per strap, and rejection of the other final byte
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55);
            check8("R1 open after three bytes", {7'd0, cfg_open}, 8'h00);
            wr(1'b0, fin_of(!s[0]));
            check8("R2 other strap final byte", {7'd0, cfg_open}, 8'h00);
            send_key(fin_of(s[0]));
            check8("R1 R2 open after full key", {7'd0, cfg_open}, 8'h01);
            close_space();
            check8("R4 closed", {7'd0, cfg_open}, 8'h00);
        end

        // R3: wrong byte at each position, both straps
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            for (int pos = 0; pos < 4; pos++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [7:0] bad;
                    bad = b[0] ? 8'h87 : 8'h00;
                    if (!(pos == 0 && b == 1)) begin
                        if (pos > 0) wr(1'b0, 8'h87);
                        if (pos > 1) wr(1'b0, 8'h01);
                        if (pos > 2) wr(1'b0, 8'h55);
                        wr(1'b0, bad);
                        check8("R3 locked after wrong byte", {7'd0, cfg_open}, 8'h00);
                        wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, fin_of(s[0]));
                        check8("R3 restart rule", {7'd0, cfg_open}, {7'd0, b[0]});
                        if (cfg_open) close_space();
                    end
                end
            end
        end

        // R5, R9: identity and index readback
        do_reset(1'b0);
        send_key(8'h55);
        reg_rd(8'h20, v);
        check8("R5 id high", v, 8'h87);
        reg_rd(8'h21, v);
        check8("R5 id low", v, 8'h16);
        rd(1'b0, v);
        check8("R9 index readback", v, 8'h21);
        wr(1'b1, 8'h33);
        reg_rd(8'h21, v);
        check8("R7 id write ignored", v, 8'h16);

        // R7: full sweep of device registers
        for (int l = 0; l < NUM_LDN; l++) begin
            reg_wr(8'h07, 8'(l));
            for (int r = 0; r < DEV_REGS; r++)
                reg_wr(8'(8'h30 + r), 8'((l * 37 + r * 5 + 3) & 8'hFF));
        end
        for (int l = 0; l < NUM_LDN; l++) begin
            reg_wr(8'h07, 8'(l));
            reg_rd(8'h07, v);
            check8("R7 ldn readback", v, 8'(l));
            for (int r = 0; r < DEV_REGS; r++) begin
                reg_rd(8'(8'h30 + r), v);
                check8("R7 device register", v, 8'((l * 37 + r * 5 + 3) & 8'hFF));
            end
        end
        reg_wr(8'h07, 8'h05);
        reg_rd(8'h07, v);
        check8("R7 ldn truncation", v, 8'h01);
        reg_wr(8'h40, 8'h5A);
        reg_rd(8'h40, v);
        check8("R7 unmapped above", v, 8'h00);
        reg_wr(8'h2F, 8'h5A);
        reg_rd(8'h2F, v);
        check8("R7 unmapped below", v, 8'h00);

        // R9: read data holds with no strobe
        reg_rd(8'h20, v);
        wr(1'b0, 8'h21);
        @(negedge clk);
        check8("R9 read hold", rd_data, 8'h87);

        // R4: non-closing writes
        reg_wr(8'h02, 8'h01);
        check8("R4 other value keeps open", {7'd0, cfg_open}, 8'h01);
        reg_wr(8'h03, 8'h02);
        check8("R4 other index keeps open", {7'd0, cfg_open}, 8'h01);

        // R6: locked writes are ignored
        reg_wr(8'h07, 8'h00);
        reg_wr(8'h30, 8'h11);
        close_space();
        check8("R4 close", {7'd0, cfg_open}, 8'h00);
        wr(1'b1, 8'h99);
        wr(1'b0, 8'h07);
        wr(1'b1, 8'h03);
        send_key(8'h55);
        rd(1'b0, v);
        check8("R4 index cleared on close", v, 8'h00);
        reg_rd(8'h07, v);
        check8("R6 ldn untouched", v, 8'h00);
        reg_rd(8'h30, v);
        check8("R6 register untouched", v, 8'h11);

        // R8: reset while open
        reg_wr(8'h07, 8'h02);
        do_reset(1'b0);
        check8("R8 locked after reset", {7'd0, cfg_open}, 8'h00);
        send_key(8'h55);
        reg_rd(8'h07, v);
        check8("R8 ldn zero", v, 8'h00);
        reg_rd(8'h30, v);
        check8("R8 register cleared", v, 8'h00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule